// File: doc/BRIEF.md
# Pipelined bfloat16 Multiplier (truncating)

This block multiplies two 16-bit brain-float operands. Each operand is a sign bit at position 15, an 8-bit biased exponent in bits 14:7 and a 7-bit fraction in bits 6:0. The result sign is the exclusive OR of the two operand signs. The two biased exponents are added and one bias of 127 is taken off. The two 8-bit significands, each with its hidden one restored, are multiplied. The low 7 bits of the product are dropped, and the remaining value is renormalized by a right shift of at most one place. No rounding is done and nothing saturates. The exponent wraps modulo 256, so callers must keep their operands inside a range where the result exponent fits.

The datapath is split into a front half (unpacking, sign, exponent sum and product) and a back half (normalization and packing). A parameter chooses one or two register stages. Each stage is a small slot machine with two states. `SLOT_EMPTY` moves to `SLOT_FULL` when its input is valid (transition *fill*). `SLOT_FULL` stays full on a further valid input (*refill*) and goes back to `SLOT_EMPTY` when no valid input arrives (*drain*). `SLOT_EMPTY` stays empty when its input is idle (*idle*). A slot loads its data only on a valid input, so the output word holds its last value between operations. A new operation can be issued every cycle.

Top module: `bf16_mul_pipe`

## Requirements
- R1: Result bit 15 equals the XOR of bit 15 of `op_a` and bit 15 of `op_b`, including for zero results.
- R2: For nonzero operands, result bits 14:7 equal (ea + eb − 127 + n) where ea and eb are operand bits 14:7 and n is 1 when the truncated product reaches 256, otherwise 0.
- R3: The exponent is computed in a 10-bit signed intermediate and only its low 8 bits are packed, so sums above 255 or below 0 wrap modulo 256 with no flag.
- R4: For nonzero operands, with P = ((128 | fa) × (128 | fb)) >> 7 where fa and fb are operand bits 6:0, result bits 6:0 are the low 7 bits of P when P < 256, and the low 7 bits of P >> 1 otherwise; no rounding.
- R5: An operand whose bits 14:0 are all zero gives a result whose bits 14:0 are zero, keeping the sign of R1.
- R6: `valid_out` is `valid_in` delayed by `STAGES` clock cycles (default 2), and `product` carries the matching result in the cycle `valid_out` is high.
- R7: When no valid operation reaches the output stage, `product` holds its previous value whatever the operand inputs do.
- R8: While `rst_n` is low, `valid_out` is 0 and `product` is 0x0000.
- R9: Operations issued on consecutive cycles, or with idle gaps between them, come out in issue order, one per cycle, keeping the gaps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| valid_in | input | 1 | Operands on `op_a`/`op_b` are to be multiplied |
| op_a | input | 16 | First bfloat16 operand |
| op_b | input | 16 | Second bfloat16 operand |
| valid_out | output | 1 | `product` holds a new result this cycle |
| product | output | 16 | Packed bfloat16 result |

## Verification
Known operand pairs are tried where the truncated product stays below 256 and where it reaches 256. These show whether the one-place renormalization and its exponent increment are taken. Pairs with maximal and minimal exponents separate correct modulo-256 wrapping from saturation or a wrong bias. Signed-zero operands on either side show the zero bypass and sign handling. Streams with gaps, and idle periods with changing operands, tell apart correct latency, ordering and hold behaviour from a stage that loads unconditionally.

// File: rtl/bf16m_pkg.sv
package bf16m_pkg;

    localparam int BF_EXP_W  = 8;
    localparam int BF_FRAC_W = 7;
    localparam int BF_WORD_W = 1 + BF_EXP_W + BF_FRAC_W;
    localparam int BF_SIG_W  = BF_FRAC_W + 1;
    localparam int BF_PROD_W = 2 * BF_SIG_W;
    localparam int BF_PSH_W  = BF_SIG_W + 1;
    localparam int BF_EXPI_W = BF_EXP_W + 2;
    localparam int BF_BIAS   = (1 << (BF_EXP_W - 1)) - 1;

    typedef struct packed {
        logic                        sign;
        logic                        zero;
        logic signed [BF_EXPI_W-1:0] exp_sum;
        logic [BF_PSH_W-1:0]         prod;
    } bf_mid_t;

    typedef enum logic {
        SLOT_EMPTY = 1'b0,
        SLOT_FULL  = 1'b1
    } slot_state_t;

endpackage

// File: rtl/bf16m_unpack.sv
module bf16m_unpack
    import bf16m_pkg::*;
(
    input  logic [BF_WORD_W-1:0] word,
    output logic                 sign,
    output logic [BF_EXP_W-1:0]  exp_f,
    output logic [BF_SIG_W-1:0]  sig,
    output logic                 is_zero
);

    always_comb begin
        sign    = word[BF_WORD_W-1];
        exp_f   = word[BF_WORD_W-2 -: BF_EXP_W];
        // hidden one restored above the stored fraction
        sig     = {1'b1, word[BF_FRAC_W-1:0]};
        is_zero = (word[BF_WORD_W-2:0] == '0);
    end

endmodule

// File: rtl/bf16m_front.sv
module bf16m_front
    import bf16m_pkg::*;
(
    input  logic [BF_WORD_W-1:0] op_a,
    input  logic [BF_WORD_W-1:0] op_b,
    output bf_mid_t              mid
);

    localparam int N_OPS = 2;

    logic [BF_WORD_W-1:0] ops   [N_OPS];
    logic                 sgn   [N_OPS];
    logic [BF_EXP_W-1:0]  expf  [N_OPS];
    logic [BF_SIG_W-1:0]  sigf  [N_OPS];
    logic                 zro   [N_OPS];

    assign ops[0] = op_a;
    assign ops[1] = op_b;

    for (genvar i = 0; i < N_OPS; i++) begin : g_unpack
        bf16m_unpack u_unpack (
            .word    (ops[i]),
            .sign    (sgn[i]),
            .exp_f   (expf[i]),
            .sig     (sigf[i]),
            .is_zero (zro[i])
        );
    end

    logic [BF_PROD_W-1:0]         full_prod;
    logic signed [BF_EXPI_W-1:0]  exp_a_w;
    logic signed [BF_EXPI_W-1:0]  exp_b_w;

    always_comb begin
        full_prod   = sigf[0] * sigf[1];
        exp_a_w     = signed'({{(BF_EXPI_W-BF_EXP_W){1'b0}}, expf[0]});
        exp_b_w     = signed'({{(BF_EXPI_W-BF_EXP_W){1'b0}}, expf[1]});
        mid.sign    = sgn[0] ^ sgn[1];
        mid.zero    = zro[0] | zro[1];
        mid.exp_sum = exp_a_w + exp_b_w - BF_EXPI_W'(BF_BIAS);
        // drop the low fraction-width bits of the product (truncation)
        mid.prod    = full_prod[BF_PROD_W-1:BF_FRAC_W];
    end

endmodule

// File: rtl/bf16m_back.sv
module bf16m_back
    import bf16m_pkg::*;
(
    input  bf_mid_t              mid,
    output logic [BF_WORD_W-1:0] word
);

    logic                        carry;
    logic signed [BF_EXPI_W-1:0] exp_n;
    logic [BF_FRAC_W-1:0]        frac_n;

    always_comb begin
        carry = mid.prod[BF_PSH_W-1];
        if (carry) begin
            exp_n  = mid.exp_sum + BF_EXPI_W'(1);
            frac_n = mid.prod[BF_FRAC_W:1];
        end else begin
            exp_n  = mid.exp_sum;
            frac_n = mid.prod[BF_FRAC_W-1:0];
        end
        if (mid.zero) begin
            word = {mid.sign, {(BF_WORD_W-1){1'b0}}};
        end else begin
            word = {mid.sign, exp_n[BF_EXP_W-1:0], frac_n};
        end
    end

endmodule

// File: rtl/bf16m_slot.sv
module bf16m_slot
    import bf16m_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    output logic [W-1:0] out_data
);

    slot_state_t state_q;
    slot_state_t state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_EMPTY: state_d = in_valid ? SLOT_FULL : SLOT_EMPTY; // fill / idle
            SLOT_FULL:  state_d = in_valid ? SLOT_FULL : SLOT_EMPTY; // refill / drain
            default:    state_d = SLOT_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SLOT_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_data <= '0;
        end else if (in_valid) begin
            out_data <= in_data;
        end
    end

    always_comb begin
        out_valid = (state_q == SLOT_FULL);
    end

endmodule

// File: rtl/bf16_mul_pipe.sv
module bf16_mul_pipe
    import bf16m_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 valid_in,
    input  logic [BF_WORD_W-1:0] op_a,
    input  logic [BF_WORD_W-1:0] op_b,
    output logic                 valid_out,
    output logic [BF_WORD_W-1:0] product
);

    localparam int MID_W = $bits(bf_mid_t);

    bf_mid_t mid_c;

    bf16m_front u_front (
        .op_a (op_a),
        .op_b (op_b),
        .mid  (mid_c)
    );

    if (STAGES >= 2) begin : g_two
        logic [MID_W-1:0]     mid_bits;
        bf_mid_t              mid_q;
        logic                 mid_v;
        logic [BF_WORD_W-1:0] word_c;

        bf16m_slot #(.W(MID_W)) u_slot_mid (
            .clk       (clk),
            .rst_n     (rst_n),
            .in_valid  (valid_in),
            .in_data   (mid_c),
            .out_valid (mid_v),
            .out_data  (mid_bits)
        );

        assign mid_q = mid_bits;

        bf16m_back u_back (
            .mid  (mid_q),
            .word (word_c)
        );

        bf16m_slot #(.W(BF_WORD_W)) u_slot_out (
            .clk       (clk),
            .rst_n     (rst_n),
            .in_valid  (mid_v),
            .in_data   (word_c),
            .out_valid (valid_out),
            .out_data  (product)
        );
    end else begin : g_one
        logic [BF_WORD_W-1:0] word_c;

        bf16m_back u_back (
            .mid  (mid_c),
            .word (word_c)
        );

        bf16m_slot #(.W(BF_WORD_W)) u_slot_out (
            .clk       (clk),
            .rst_n     (rst_n),
            .in_valid  (valid_in),
            .in_data   (word_c),
            .out_valid (valid_out),
            .out_data  (product)
        );
    end

endmodule

// File: rtl/bf16_mul_pipe_checker.sv
module bf16_mul_pipe_checker #(
    parameter int STAGES = 2
) (
    input logic        clk,
    input logic        rst_n,
    input logic        valid_in,
    input logic [15:0] op_a,
    input logic [15:0] op_b,
    input logic        valid_out,
    input logic [15:0] product
);

    // R8: outputs are known and idle in reset
    always_comb begin
        if (!rst_n) begin
            assert_reset_idle_R8: assert (valid_out == 1'b0 && product == 16'h0000);
        end
    end

    // R7: result word moves only when a result is delivered
    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_out |-> $stable(product));

    if (STAGES >= 2) begin : g_chk2
        assert_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
            valid_out == $past(valid_in, 2));
        assert_sign_xor_R1: assert property (@(posedge clk) disable iff (!rst_n)
            valid_out |-> product[15] == $past(op_a[15] ^ op_b[15], 2));
        assert_zero_operand_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (valid_out && $past(op_a[14:0] == 15'h0 || op_b[14:0] == 15'h0, 2))
            |-> product[14:0] == 15'h0);
    end else begin : g_chk1
        assert_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
            valid_out == $past(valid_in, 1));
        assert_sign_xor_R1: assert property (@(posedge clk) disable iff (!rst_n)
            valid_out |-> product[15] == $past(op_a[15] ^ op_b[15], 1));
        assert_zero_operand_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (valid_out && $past(op_a[14:0] == 15'h0 || op_b[14:0] == 15'h0, 1))
            |-> product[14:0] == 15'h0);
    end

endmodule

bind bf16_mul_pipe bf16_mul_pipe_checker #(.STAGES(STAGES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid_in  (valid_in),
    .op_a      (op_a),
    .op_b      (op_b),
    .valid_out (valid_out),
    .product   (product)
);

// File: tb/bf16_mul_pipe_bench.sv
module bf16_mul_pipe_bench;

    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 2;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_in = 1'b0;
    logic [15:0] op_a = 16'h0;
    logic [15:0] op_b = 16'h0;
    logic        valid_out;
    logic [15:0] product;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    bf16_mul_pipe #(.STAGES(LAT)) u_bf16_mul_pipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid_in  (valid_in),
        .op_a      (op_a),
        .op_b      (op_b),
        .valid_out (valid_out),
        .product   (product)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // expected result built from R1..R5
    function automatic logic [15:0] model(input logic [15:0] a, input logic [15:0] b);
        int p;
        int e;
        logic s;
        s = a[15] ^ b[15];
        if (a[14:0] == 15'h0 || b[14:0] == 15'h0) return {s, 15'h0};
        p = ((128 + int'(a[6:0])) * (128 + int'(b[6:0]))) >> 7;
        e = int'(a[14:7]) + int'(b[14:7]) - 127;
        if (p >= 256) begin
            p = p >> 1;
            e = e + 1;
        end
        return {s, e[7:0], p[6:0]};
    endfunction

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    task automatic run_one(input string req, input logic [15:0] a,
                           input logic [15:0] b, input logic [15:0] exp);
        @(negedge clk);
        op_a = a;
        op_b = b;
        valid_in = 1'b1;
        @(negedge clk);
        valid_in = 1'b0;
        repeat (LAT - 1) @(negedge clk);
        check({req, " valid_out"}, {15'h0, valid_out}, 16'h1);
        check(req, product, exp);
        check({req, " model"}, product, model(a, b));
    endtask

    task automatic t_reset;
        #(CLK_PERIOD*2 + 1);
        check("R8 valid_out in reset", {15'h0, valid_out}, 16'h0);
        check("R8 product in reset", product, 16'h0000);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8 valid_out after reset", {15'h0, valid_out}, 16'h0);
    endtask

    task automatic t_known_vectors;
        run_one("R4 no renorm", 16'h411D, 16'h4126, 16'h42CB);
        run_one("R2 renorm exp+1", 16'h426B, 16'h429E, 16'h4591);
        run_one("R1 neg x neg", 16'hC117, 16'hC178, 16'h4312);
        run_one("R1 neg x pos", 16'hC2C8, 16'h4285, 16'hC5CF);
        run_one("R2 one x one", 16'h3F80, 16'h3F80, 16'h3F80);
    endtask

    task automatic t_exponent_wrap;
        run_one("R3 overflow wrap", 16'h7F80, 16'h7F80, 16'h3F80);
        run_one("R3 underflow wrap", 16'h0080, 16'h0080, 16'h4180);
        run_one("R3 max sig wrap", 16'h7FFF, 16'h7FFF, 16'h407E);
    endtask

    task automatic t_zero_operands;
        run_one("R5 zero a", 16'h0000, 16'h4126, 16'h0000);
        run_one("R5 neg zero a", 16'h8000, 16'h4126, 16'h8000);
        run_one("R5 neg zero b", 16'h4126, 16'h8000, 16'h8000);
        run_one("R5 zero times neg", 16'h0000, 16'hC2C8, 16'h8000);
    endtask

    task automatic t_hold;
        run_one("R7 setup", 16'h411D, 16'h4126, 16'h42CB);
        for (int k = 0; k < 4; k++) begin
            op_a = 16'h1234 + 16'(k);
            op_b = 16'hC321 - 16'(k);
            @(negedge clk);
            check("R7 product held", product, 16'h42CB);
            check("R7 valid_out low", {15'h0, valid_out}, 16'h0);
        end
    endtask

    task automatic t_stream;
        localparam int N = 8;
        logic [15:0] sa [N];
        logic [15:0] sb [N];
        logic        sv [N];
        sa = '{16'h411D, 16'h426B, 16'hC117, 16'h1111, 16'hC2C8, 16'h3F80, 16'h8000, 16'h7FFF};
        sb = '{16'h4126, 16'h429E, 16'hC178, 16'h2222, 16'h4285, 16'h4000, 16'h3F80, 16'h3F80};
        sv = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1};
        for (int k = 0; k < N + LAT; k++) begin
            @(negedge clk);
            if (k >= LAT) begin
                check("R9 stream valid", {15'h0, valid_out}, {15'h0, sv[k-LAT]});
                if (sv[k-LAT]) check("R9 stream data", product, model(sa[k-LAT], sb[k-LAT]));
            end
            if (k < N) begin
                op_a = sa[k];
                op_b = sb[k];
                valid_in = sv[k];
            end else begin
                valid_in = 1'b0;
            end
        end
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_known_vectors();
        t_exponent_wrap();
        t_zero_operands();
        t_hold();
        t_stream();
        repeat (2) @(negedge clk);
        check("R6 idle after stream", {15'h0, valid_out}, 16'h0);
        finish_run();
    end

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

endmodule